// File: doc/BRIEF.md
# Dual-Channel Latched Bidirectional Bus Transceiver

This block is a clocked, synthesizable model of a two-channel bidirectional bus transceiver. Each channel is 8 bits wide. It has one storage register that carries data from the A side to the B side and a second that carries data from B to A. Each direction has three active-low controls: a path enable, a latch enable and a driver enable. Pads are split into an input vector, an output vector and a per-bit output-enable vector on each side, so the block needs no tri-state primitive. A surrounding pad ring or a testbench resolves the bus.

All inputs are sampled on the rising clock edge. While a direction's path enable and latch enable are both sampled low, its storage reloads from the opposite side's inputs on every clock, so the output follows the input one cycle late. Once either enable is sampled high, the storage holds the data taken on the last clock on which both were low. This means a rising edge on either control acts as the capture point. A direction drives its side only while its path enable and driver enable are both low. Storage keeps working while the driver is off, so a value can be captured first and shown later. A per-channel flag reports when both directions of a channel drive at the same time.

Top module: `latched_bus_xcvr`

## Requirements
- R1: While reset is asserted, and on the first clock after it, every output-enable bit is 0 and the clash flags are 0. All four storage registers are cleared to zero, so a direction whose driver is enabled without opening its storage shows 0x00.
- R2: When the A-to-B path enable and latch enable of a channel are both sampled low on a clock edge, that channel's B output equals the A input sampled on that edge from the next cycle onward.
- R3: A rising edge on the latch enable or on the path enable freezes the stored value. The output keeps the data sampled on the clock before the edge was seen, even if the A input changes on the same clock as the control.
- R4: A channel's B output-enable bits are all 1 exactly when its A-to-B path enable and driver enable were both sampled low on the previous clock edge. Otherwise they are all 0.
- R5: While the latch enable or path enable of a direction is sampled high, its output value does not change, whatever its data inputs do.
- R6: Data captured while the driver enable is high is driven unchanged once the driver enable goes low with the path enable low and the latch enable high.
- R7: The B-to-A direction behaves like R2 to R6, using the B inputs, the A outputs and its own three controls.
- R8: The two channels are independent. The controls and data of one channel never change the outputs of the other. Channel c occupies bits [8c+7:8c] of every data vector and bit c of every control vector.
- R9: The clash flag of a channel is 1 exactly when both of its directions are driving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Active-low reset modelling power-up |
| ab_en_n | input | NCH | A-to-B path enable per channel, active low |
| ab_le_n | input | NCH | A-to-B latch enable per channel, active low |
| ab_oe_n | input | NCH | A-to-B driver enable per channel, active low |
| ba_en_n | input | NCH | B-to-A path enable per channel, active low |
| ba_le_n | input | NCH | B-to-A latch enable per channel, active low |
| ba_oe_n | input | NCH | B-to-A driver enable per channel, active low |
| a_in | input | NCH*W | Value seen on the A pads |
| b_in | input | NCH*W | Value seen on the B pads |
| a_out | output | NCH*W | Value to drive onto the A pads |
| a_oe | output | NCH*W | Per-bit drive enable for the A pads |
| b_out | output | NCH*W | Value to drive onto the B pads |
| b_oe | output | NCH*W | Per-bit drive enable for the B pads |
| clash | output | NCH | Per-channel flag: both directions are driving |

## Verification
The assertions assume that the controls and data are stable around each rising clock edge. They also assume that a capture is judged only by the values seen at those edges, so a pulse narrower than a clock period counts as if it never happened. The stimulus changes every input only on the falling edge, at most once per cycle. Random control patterns therefore produce edges on the latch and path enables in every combination, and each one is still sampled cleanly. The bench also drives the case where data changes on the same cycle as the capturing control, which shows that the value from the cycle before is the one kept.

// File: rtl/latched_bus_xcvr.sv
`timescale 1ns/1ps
module latched_bus_xcvr #(
  parameter int NCH = 2,
  parameter int W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     ab_en_n,
  input  logic [NCH-1:0]     ab_le_n,
  input  logic [NCH-1:0]     ab_oe_n,
  input  logic [NCH-1:0]     ba_en_n,
  input  logic [NCH-1:0]     ba_le_n,
  input  logic [NCH-1:0]     ba_oe_n,
  input  logic [NCH*W-1:0]   a_in,
  input  logic [NCH*W-1:0]   b_in,
  output logic [NCH*W-1:0]   a_out,
  output logic [NCH*W-1:0]   a_oe,
  output logic [NCH*W-1:0]   b_out,
  output logic [NCH*W-1:0]   b_oe,
  output logic [NCH-1:0]     clash
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [W-1:0] st_ab, st_ba;
    logic         drv_ab, drv_ba;
    logic         open_ab, open_ba;

    assign open_ab = ~ab_en_n[ch] & ~ab_le_n[ch];
    assign open_ba = ~ba_en_n[ch] & ~ba_le_n[ch];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_ab  <= '0;
        st_ba  <= '0;
        drv_ab <= 1'b0;
        drv_ba <= 1'b0;
      end else begin
        if (open_ab) st_ab <= a_in[ch*W +: W];
        if (open_ba) st_ba <= b_in[ch*W +: W];
        drv_ab <= ~ab_en_n[ch] & ~ab_oe_n[ch];
        drv_ba <= ~ba_en_n[ch] & ~ba_oe_n[ch];
      end
    end

    assign b_out[ch*W +: W] = st_ab;
    assign a_out[ch*W +: W] = st_ba;
    assign b_oe[ch*W +: W]  = {W{drv_ab}};
    assign a_oe[ch*W +: W]  = {W{drv_ba}};
    assign clash[ch]        = drv_ab & drv_ba;

    a_r2_ab_follow: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(ab_en_n[ch]) && !$past(ab_le_n[ch]))
      |-> b_out[ch*W +: W] == $past(a_in[ch*W +: W]));

    a_r5_ab_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && ($past(ab_en_n[ch]) || $past(ab_le_n[ch])))
      |-> $stable(b_out[ch*W +: W]));

    a_r4_ab_drive: assert property (@(posedge clk) disable iff (!rst_n)
      b_oe[ch*W] |-> (!$past(ab_en_n[ch]) && !$past(ab_oe_n[ch])));

    a_r7_ba_follow: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(ba_en_n[ch]) && !$past(ba_le_n[ch]))
      |-> a_out[ch*W +: W] == $past(b_in[ch*W +: W]));

    a_r7_ba_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && ($past(ba_en_n[ch]) || $past(ba_le_n[ch])))
      |-> $stable(a_out[ch*W +: W]));

    a_r9_clash: assert property (@(posedge clk) disable iff (!rst_n)
      clash[ch] |-> (!$past(ab_en_n[ch]) && !$past(ab_oe_n[ch]) &&
                     !$past(ba_en_n[ch]) && !$past(ba_oe_n[ch])));
  end

endmodule

// File: tb/latched_bus_xcvr_tb.sv
`timescale 1ns/1ps
module latched_bus_xcvr_tb;
  localparam int NCH = 2;
  localparam int W   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] ab_en_n = '1, ab_le_n = '1, ab_oe_n = '1;
  logic [NCH-1:0] ba_en_n = '1, ba_le_n = '1, ba_oe_n = '1;
  logic [NCH*W-1:0] a_in = '0, b_in = '0;
  logic [NCH*W-1:0] a_out, a_oe, b_out, b_oe;
  logic [NCH-1:0] clash;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] m_ab [NCH];
  logic [W-1:0] m_ba [NCH];
  logic         m_oab [NCH];
  logic         m_oba [NCH];

  always #2 clk = ~clk;

  latched_bus_xcvr #(.NCH(NCH), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
    .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe), .clash(clash));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] sl(input logic [NCH*W-1:0] v, input int c);
    return v[c*W +: W];
  endfunction

  task automatic cyc();
    @(posedge clk);
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n) begin
        m_ab[c] = '0; m_ba[c] = '0; m_oab[c] = 1'b0; m_oba[c] = 1'b0;
      end else begin
        if (!ab_en_n[c] && !ab_le_n[c]) m_ab[c] = sl(a_in, c);
        if (!ba_en_n[c] && !ba_le_n[c]) m_ba[c] = sl(b_in, c);
        m_oab[c] = !ab_en_n[c] && !ab_oe_n[c];
        m_oba[c] = !ba_en_n[c] && !ba_oe_n[c];
      end
    end
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      chk(sl(b_out, c) == m_ab[c], "R2 b_out", sl(b_out, c), m_ab[c]);
      chk(sl(b_oe, c) == {W{m_oab[c]}}, "R4 b_oe", sl(b_oe, c), {W{m_oab[c]}});
      chk(sl(a_out, c) == m_ba[c], "R7 a_out", sl(a_out, c), m_ba[c]);
      chk(sl(a_oe, c) == {W{m_oba[c]}}, "R7 a_oe", sl(a_oe, c), {W{m_oba[c]}});
      chk(clash[c] == (m_oab[c] && m_oba[c]), "R9 clash", clash[c], m_oab[c] && m_oba[c]);
    end
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h1A2B);
    cyc(); cyc();
    chk(a_oe == '0 && b_oe == '0, "R1 oe in reset", {a_oe[7:0], b_oe[7:0]}, 0);
    chk(clash == '0, "R1 clash in reset", clash, 0);
    rst_n = 1'b1;
    cyc();
    chk(b_oe == '0 && a_oe == '0, "R1 oe after release", {a_oe[7:0], b_oe[7:0]}, 0);

    // R1: driver on, storage not opened -> cleared value visible
    ab_en_n[0] = 0; ab_oe_n[0] = 0; a_in[7:0] = 8'hE7;
    cyc();
    chk(b_out[7:0] == 8'h00 && b_oe[7:0] == 8'hFF, "R1 storage zero", b_out[7:0], 8'h00);

    // R2 transparent
    ab_le_n[0] = 0; a_in[7:0] = 8'h5A;
    cyc();
    chk(b_out[7:0] == 8'h5A, "R2 transparent", b_out[7:0], 8'h5A);
    // R3 latch-enable rise with data changing on the same clock
    ab_le_n[0] = 1; a_in[7:0] = 8'hC3;
    cyc();
    chk(b_out[7:0] == 8'h5A, "R3 capture on latch rise", b_out[7:0], 8'h5A);
    // R5 hold
    a_in[7:0] = 8'h11; cyc(); a_in[7:0] = 8'hEE; cyc();
    chk(b_out[7:0] == 8'h5A, "R5 hold", b_out[7:0], 8'h5A);

    // R3 path-enable rise
    ab_le_n[0] = 0; a_in[7:0] = 8'h77;
    cyc();
    ab_en_n[0] = 1; a_in[7:0] = 8'h22;
    cyc();
    chk(b_oe[7:0] == 8'h00, "R4 path enable high disables", b_oe[7:0], 8'h00);
    chk(b_out[7:0] == 8'h77, "R3 capture on path rise", b_out[7:0], 8'h77);
    ab_le_n[0] = 1; ab_en_n[0] = 0;
    cyc();
    chk(b_out[7:0] == 8'h77 && b_oe[7:0] == 8'hFF, "R3 shown after path low", b_out[7:0], 8'h77);

    // R6 capture while driver off
    ab_oe_n[0] = 1; ab_le_n[0] = 0; a_in[7:0] = 8'h99;
    cyc();
    chk(b_oe[7:0] == 8'h00, "R4 driver enable high", b_oe[7:0], 8'h00);
    ab_le_n[0] = 1; a_in[7:0] = 8'h01;
    cyc();
    ab_oe_n[0] = 0;
    cyc();
    chk(b_out[7:0] == 8'h99 && b_oe[7:0] == 8'hFF, "R6 late display", b_out[7:0], 8'h99);

    // R8 channel 1 untouched so far
    chk(b_oe[15:8] == 8'h00 && b_out[15:8] == 8'h00 && a_out[15:8] == 8'h00, "R8 independence",
        {a_out[15:8], b_out[15:8]}, 0);

    // R7 reverse path on channel 1, R9 clash
    ba_en_n[1] = 0; ba_le_n[1] = 0; ba_oe_n[1] = 0; b_in[15:8] = 8'h3C;
    cyc();
    chk(a_out[15:8] == 8'h3C && a_oe[15:8] == 8'hFF, "R7 reverse transparent", a_out[15:8], 8'h3C);
    chk(a_out[7:0] == 8'h00 && b_out[7:0] == 8'h99, "R8 channel 0 unaffected", {a_out[7:0], b_out[7:0]}, 16'h0099);
    ab_en_n[1] = 0; ab_oe_n[1] = 0;
    cyc();
    chk(clash == 2'b10, "R9 clash channel 1", clash, 2'b10);
    ba_oe_n[1] = 1;
    cyc();
    chk(clash == 2'b00, "R9 clash cleared", clash, 2'b00);

    // random stimulus, reference-checked every cycle
    for (int i = 0; i < 3000; i++) begin
      ab_en_n = NCH'($urandom % 4 == 0 ? '1 : $urandom);
      ab_le_n = NCH'($urandom);
      ab_oe_n = NCH'($urandom);
      ba_en_n = NCH'($urandom % 4 == 0 ? '1 : $urandom);
      ba_le_n = NCH'($urandom);
      ba_oe_n = NCH'($urandom);
      a_in = (NCH*W)'($urandom);
      b_in = (NCH*W)'($urandom);
      if (i == 1500) rst_n = 1'b0;
      if (i == 1503) rst_n = 1'b1;
      cyc();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule